// File: doc/BRIEF.md
# Snoop-Aware CPU Bus Arbiter

This block shares one CPU-side bus between a CPU with a write-back cache and a second bus master, such as a bridge or a DMA engine. The CPU owns the bus by default. When the master requests the bus, the arbiter raises a hold request to the CPU. It grants the bus to the master only after the CPU acknowledges the hold. While the master owns the bus, it can start a cache inquiry. The arbiter forwards that inquiry strobe to the CPU and then watches a fixed window for the CPU's dirty-hit indication.

On a dirty hit, the arbiter withdraws the grant and drops hold, so the CPU can write the modified line back. As soon as the CPU's address strobe shows that the write-back has started, the arbiter raises hold again. This keeps the CPU from starting any further cycle. Once the CPU reports ready and acknowledges hold again, the master gets the bus back without having to request it again. All interfaces run from one clock.

States: IDLE (CPU owns the bus), ACQUIRE (hold raised, waiting for the acknowledge), OWNED (master granted), SNOOP (inquiry window open), YIELD (bus returned for the write-back), WB_HOLD (hold raised again, waiting for ready), WB_DONE (waiting for the acknowledge to return). Transitions:
- IDLE→ACQUIRE on request.
- ACQUIRE→IDLE when the request is dropped.
- ACQUIRE→OWNED on acknowledge.
- OWNED→IDLE when the request is dropped.
- OWNED→SNOOP on an inquiry strobe.
- SNOOP→YIELD on a dirty hit.
- SNOOP→OWNED when the window expires.
- YIELD→WB_HOLD on the CPU address strobe.
- WB_HOLD→WB_DONE on ready.
- WB_DONE→OWNED or IDLE on acknowledge, depending on whether the request is still present.

Top module: `cpu_bus_arbiter`

## Requirements
- R1: After reset, cpu_hold, mst_gnt and cpu_inq are all 0.
- R2: With mst_req low, cpu_hold and mst_gnt stay 0 and the CPU keeps the bus.
- R3: mst_req high raises cpu_hold on the next clock. mst_gnt rises one clock after cpu_hlda is first sampled high while hold is raised.
- R4: mst_gnt is never 1 unless both cpu_hold and cpu_hlda are 1, so the grant never overlaps CPU bus ownership.
- R5: If the master drops mst_req while it owns the bus with no inquiry open, mst_gnt and cpu_hold both fall on the next clock.
- R6: cpu_inq follows mst_inq combinationally only while the master owns the bus and no inquiry window is open. An mst_inq during a window is not forwarded.
- R7: A cpu_hit_dirty sampled in any of the SNOOP_WIN (default 3) clocks after the inquiry strobe drops mst_gnt and cpu_hold on the next clock.
- R8: While the bus is yielded, a sampled cpu_addr_stb raises cpu_hold on the next clock, and mst_gnt stays 0 through the write-back.
- R9: After cpu_ready and then cpu_hlda are sampled, mst_gnt returns on the next clock if mst_req is still high, with no new request edge. If mst_req is low by then, the arbiter goes idle with cpu_hold at 0.
- R10: If no dirty hit arrives inside the window, the master keeps the bus without interruption. A dirty hit on the clock after the window is ignored.
- R11: mst_req is ignored while an inquiry window is open. The grant holds until the window resolves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_req | input | 1 | Bus request from the second master |
| mst_inq | input | 1 | Cache inquiry strobe from the master |
| cpu_hlda | input | 1 | Hold acknowledge from the CPU |
| cpu_hit_dirty | input | 1 | CPU reports that the inquiry hit a modified line |
| cpu_addr_stb | input | 1 | CPU address strobe (start of a CPU cycle) |
| cpu_ready | input | 1 | CPU cycle completion |
| mst_gnt | output | 1 | Bus grant to the master |
| cpu_hold | output | 1 | Hold request to the CPU |
| cpu_inq | output | 1 | Inquiry strobe forwarded to the CPU |

## Verification
A wrong state shows up at the ports within one clock. Every state fixes the pair cpu_hold/mst_gnt, and that pair is compared after each edge. A window counter that is off by one either honours a dirty hit on the clock after the window or misses one on the last clock of it. That shows up as a grant that drops or stays up one clock after the stimulus. A missed return path after the write-back appears as a grant that does not come back on the clock after the acknowledge. A dropped request that is wrongly honoured during the window appears as an early release inside the window.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_OWNED,
        ST_SNOOP,
        ST_YIELD,
        ST_WB_HOLD,
        ST_WB_DONE
    } arb_state_e;
endpackage

// File: rtl/arb_snoop_timer.sv
module arb_snoop_timer #(
    parameter int WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt;

    // Counts the clocks spent with the window open; cleared whenever it is closed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

    assert_cnt_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mst_req,
    input  logic mst_inq,
    input  logic cpu_hlda,
    input  logic cpu_hit_dirty,
    input  logic cpu_addr_stb,
    input  logic cpu_ready,
    input  logic win_expired,
    output logic snoop_run,
    output logic mst_gnt,
    output logic cpu_hold,
    output logic cpu_inq
);
    arb_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (mst_req) state_nx = ST_ACQUIRE;
            ST_ACQUIRE: begin
                if (!mst_req)      state_nx = ST_IDLE;
                else if (cpu_hlda) state_nx = ST_OWNED;
            end
            ST_OWNED: begin
                if (!mst_req)     state_nx = ST_IDLE;
                else if (mst_inq) state_nx = ST_SNOOP;
            end
            ST_SNOOP: begin
                if (cpu_hit_dirty)    state_nx = ST_YIELD;
                else if (win_expired) state_nx = ST_OWNED;
            end
            ST_YIELD:   if (cpu_addr_stb) state_nx = ST_WB_HOLD;
            ST_WB_HOLD: if (cpu_ready)    state_nx = ST_WB_DONE;
            ST_WB_DONE: if (cpu_hlda)     state_nx = mst_req ? ST_OWNED : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        mst_gnt   = 1'b0;
        cpu_hold  = 1'b0;
        snoop_run = 1'b0;
        cpu_inq   = 1'b0;
        unique case (state)
            ST_IDLE, ST_YIELD: ;
            ST_ACQUIRE, ST_WB_HOLD, ST_WB_DONE: cpu_hold = 1'b1;
            ST_OWNED: begin
                cpu_hold = 1'b1;
                mst_gnt  = 1'b1;
                cpu_inq  = mst_inq && mst_req;
            end
            ST_SNOOP: begin
                cpu_hold  = 1'b1;
                mst_gnt   = 1'b1;
                snoop_run = 1'b1;
            end
            default: ;
        endcase
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !mst_req) |=> (!cpu_hold && !mst_gnt));
    assert_gnt_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_gnt) |-> $past(cpu_hlda));
    assert_gnt_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mst_gnt |-> (cpu_hold && cpu_hlda));
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OWNED && !mst_req) |=> (!mst_gnt && !cpu_hold));
    assert_inq_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_inq |-> (mst_gnt && !snoop_run));
    assert_hit_yield_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_run && cpu_hit_dirty) |=> (!cpu_hold && !mst_gnt));
    assert_rehold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_YIELD && cpu_addr_stb) |=> (cpu_hold && !mst_gnt));
    assert_regrant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WB_DONE && cpu_hlda && mst_req) |=> mst_gnt);
    assert_miss_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_run && win_expired && !cpu_hit_dirty) |=> (mst_gnt && cpu_hold));
    assert_req_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_run && !cpu_hit_dirty) |=> mst_gnt);
endmodule

// File: rtl/cpu_bus_arbiter.sv
module cpu_bus_arbiter #(
    parameter int SNOOP_WIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mst_req,
    input  logic mst_inq,
    input  logic cpu_hlda,
    input  logic cpu_hit_dirty,
    input  logic cpu_addr_stb,
    input  logic cpu_ready,
    output logic mst_gnt,
    output logic cpu_hold,
    output logic cpu_inq
);
    logic snoop_run;
    logic win_expired;

    arb_snoop_timer #(.WIN(SNOOP_WIN)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (snoop_run),
        .expired (win_expired)
    );

    arb_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mst_req       (mst_req),
        .mst_inq       (mst_inq),
        .cpu_hlda      (cpu_hlda),
        .cpu_hit_dirty (cpu_hit_dirty),
        .cpu_addr_stb  (cpu_addr_stb),
        .cpu_ready     (cpu_ready),
        .win_expired   (win_expired),
        .snoop_run     (snoop_run),
        .mst_gnt       (mst_gnt),
        .cpu_hold      (cpu_hold),
        .cpu_inq       (cpu_inq)
    );
endmodule

// File: tb/cpu_bus_arbiter_tb.sv
`timescale 1ns/1ps
module cpu_bus_arbiter_tb;
    localparam int SNOOP_WIN = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, inq = 1'b0, hlda = 1'b0, hit = 1'b0, ads = 1'b0, rdy = 1'b0;
    logic gnt, hold, cinq;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    cpu_bus_arbiter #(.SNOOP_WIN(SNOOP_WIN)) u_dut (
        .clk (clk), .rst_n (rst_n), .mst_req (req), .mst_inq (inq),
        .cpu_hlda (hlda), .cpu_hit_dirty (hit), .cpu_addr_stb (ads),
        .cpu_ready (rdy), .mst_gnt (gnt), .cpu_hold (hold), .cpu_inq (cinq)
    );

    function automatic logic hit_taken(input int d);
        return (d >= 1) && (d <= SNOOP_WIN);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    // R4: grant must always sit inside a raised and acknowledged hold
    always @(negedge clk) begin
        if (rst_n && !done && gnt === 1'b1)
            chk(hold && hlda, 1'b1, "R4 grant without hold+ack");
    end

    task automatic run(input int lat, input int hd, input logic keep, input int wbl);
        bit taken = 0;
        req = 1'b1;
        step;
        chk(hold, 1'b1, "R3 hold raised on request");
        chk(gnt, 1'b0, "R3 no grant before ack");
        repeat (lat) begin
            step;
            chk(gnt, 1'b0, "R4 grant waits for ack");
        end
        hlda = 1'b1;
        step;
        chk(gnt, 1'b1, "R3 grant after ack");
        inq = 1'b1;
        #1;
        chk(cinq, 1'b1, "R6 inquiry forwarded");
        step;
        inq = 1'b0;
        for (int k = 1; k <= SNOOP_WIN && !taken; k++) begin
            hit = (k == hd);
            if (k == 1) begin
                if (!keep) req = 1'b0;
                inq = 1'b1;
                #1;
                chk(cinq, 1'b0, "R6 inquiry blocked in window");
            end
            step;
            hit = 1'b0;
            inq = 1'b0;
            if (hit_taken(hd) && k == hd) begin
                taken = 1;
                chk(gnt, 1'b0, "R7 grant dropped on dirty hit");
                chk(hold, 1'b0, "R7 hold dropped on dirty hit");
            end else begin
                chk(gnt, 1'b1, keep ? "R10 grant kept in window" : "R11 request drop ignored");
                chk(hold, 1'b1, "R11 hold kept in window");
            end
        end
        if (!taken) begin
            hit = (hd == SNOOP_WIN + 1);
            step;
            hit = 1'b0;
            chk(gnt, keep, "R10 late hit ignored / miss");
            chk(hold, keep, "R10 hold after miss");
        end else begin
            hlda = 1'b0;
            ads = 1'b1;
            step;
            ads = 1'b0;
            chk(hold, 1'b1, "R8 hold back on address strobe");
            chk(gnt, 1'b0, "R8 no grant during write-back");
            repeat (wbl) begin
                step;
                chk(hold, 1'b1, "R8 hold kept during write-back");
                chk(gnt, 1'b0, "R8 grant low during write-back");
            end
            rdy = 1'b1;
            step;
            rdy = 1'b0;
            chk(hold, 1'b1, "R9 hold kept after ready");
            chk(gnt, 1'b0, "R9 no grant before ack returns");
            hlda = 1'b1;
            step;
            chk(gnt, keep, "R9 grant reissued after write-back");
            chk(hold, keep, "R9 hold after write-back");
        end
        if (keep) begin
            req = 1'b0;
            step;
            chk(gnt, 1'b0, "R5 grant released");
            chk(hold, 1'b0, "R5 hold released");
        end
        hlda = 1'b0;
        step;
        chk(hold, 1'b0, "R2 idle hold low");
        chk(gnt, 1'b0, "R2 idle no grant");
    endtask

    initial begin
        void'($urandom(32'h5EED));
        #1;
        chk(hold, 1'b0, "R1 reset hold");
        chk(gnt, 1'b0, "R1 reset grant");
        chk(cinq, 1'b0, "R1 reset inquiry");
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        repeat (4) begin
            inq = 1'b1;
            step;
            chk(hold, 1'b0, "R2 no request keeps hold low");
            chk(gnt, 1'b0, "R2 no request no grant");
            chk(cinq, 1'b0, "R6 no forward while CPU owns");
        end
        inq = 1'b0;
        run(0, 2, 1'b1, 1);
        run(1, SNOOP_WIN, 1'b1, 0);
        run(2, SNOOP_WIN + 1, 1'b1, 0);
        run(0, 1, 1'b0, 2);
        run(0, SNOOP_WIN + 2, 1'b0, 0);
        for (int i = 0; i < 40; i++) begin
            int lat = int'($urandom_range(0, 3));
            int hd  = int'($urandom_range(1, SNOOP_WIN + 2));
            logic kp = logic'($urandom_range(0, 1));
            int wbl = int'($urandom_range(0, 3));
            run(lat, hd, kp, wbl);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule